// File: doc/BRIEF.md
# Rotating-Turn Routing Switch Box

This block is the programmable crossing point of a horizontal and a vertical routing channel in a programmable-logic fabric. It has four sides, North, East, South and West. Each side carries `W` tracks, and every track on every side has one incoming and one outgoing wire. Each outgoing wire is driven by a small buffered multiplexer. That multiplexer picks one of three permitted incoming wires, one from each of the other three sides, or it leaves the wire undriven at 0. Each wire can therefore reach three others, so the flexibility is 3.

A straight-through connection keeps the track number. A turning connection moves one track up or down, and the track number wraps around the channel width. The amount of rotation depends only on where the source side sits relative to the output side.

Configuration is held in a register per output track, written through a one-word address/data port. The routing path from inputs to outputs is purely combinational.

Top module: `sbox_rotating`

## Requirements
- R1: An active-low reset (`rst_n`, asynchronous) clears every select field to 00. While reset holds, and afterwards until a write arrives, every output bit is 0 whatever the inputs are.
- R2: A select field of 00 leaves its output track undriven, so it reads 0. No output track ever has more than one enabled source.
- R3: Select 01 drives output track t from track t of the opposite side. North takes from South, South from North, East from West, and West from East.
- R4: Select 10 drives output track t from track (t+1) mod W of the side that follows the output side clockwise. North takes from East, East from South, South from West, and West from North.
- R5: Select 11 drives output track t from track (t-1) mod W of the side that follows the output side counter-clockwise. North takes from West, West from South, South from East, and East from North.
- R6: Track indices wrap. With select 10, output track W-1 takes source track 0. With select 11, output track 0 takes source track W-1.
- R7: When `cfg_we` is 1 at a rising clock edge, `cfg_sel` is stored into the field at `cfg_addr`. The address is side_code*W + track, with the side codes North=0, East=1, South=2 and West=3. The new route appears at the outputs right after that edge and not before it. When `cfg_we` is 0, nothing is stored.
- R8: A write whose address is 4*W or above changes no select field.
- R9: Writing one output's field leaves the routing of every other output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration |
| cfg_we | input | 1 | Write enable for one select field |
| cfg_addr | input | $clog2(4*W) | Field address, side_code*W + track |
| cfg_sel | input | 2 | Select value to store (00 off, 01 straight, 10 clockwise side, 11 counter-clockwise side) |
| in_n | input | W | Incoming North tracks |
| in_e | input | W | Incoming East tracks |
| in_s | input | W | Incoming South tracks |
| in_w | input | W | Incoming West tracks |
| out_n | output | W | Outgoing North tracks |
| out_e | output | W | Outgoing East tracks |
| out_s | output | W | Outgoing South tracks |
| out_w | output | W | Outgoing West tracks |

## Verification
A configuration write and live combinational routing can happen in the same cycle. The new select value then competes with input changes that arrive before the edge that stores it. The bench provokes this by changing the source inputs and presenting a write to the affected output in the same low clock phase. It judges that the output still follows the old select before the edge and follows the new route just after it. A second case writes a different field while every route is active, and confirms that the other outputs do not move.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

   typedef enum logic [1:0] {
      SIDE_N = 2'd0,
      SIDE_E = 2'd1,
      SIDE_S = 2'd2,
      SIDE_W = 2'd3
   } side_e;

   typedef enum logic [1:0] {
      SEL_OFF      = 2'd0,
      SEL_STRAIGHT = 2'd1,
      SEL_CW       = 2'd2,
      SEL_CCW      = 2'd3
   } sel_e;

   // side reached by stepping clockwise by 'steps' positions
   function automatic int side_step(input int side, input int steps);
      return (side + steps) % 4;
   endfunction

   // track index shifted by 'delta' (-1, 0, +1) with wrap at w
   function automatic int track_wrap(input int idx, input int delta, input int w);
      return (idx + delta + w) % w;
   endfunction

endpackage

// File: rtl/sbox_cfg_regs.sv
module sbox_cfg_regs #(
   parameter int NUM = 20,
   parameter int AW  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [AW-1:0]       addr,
   input  logic [1:0]          data,
   output logic [NUM-1:0][1:0] sel_q
);

   initial begin
      assert ((1 << AW) >= NUM) else $error("address width too small for field count");
   end

   logic in_range;
   assign in_range = ({1'b0, addr} < (AW+1)'(NUM));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (we && in_range) begin
         for (int k = 0; k < NUM; k++) begin
            if (addr == AW'(k)) sel_q[k] <= data;
         end
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (we && in_range) |=> (sel_q[$past(addr)] == $past(data)));   // R7

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(sel_q));   // R7

   AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !in_range) |=> $stable(sel_q));   // R8

endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux
   import sbox_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel,
   input  logic       src_straight,
   input  logic       src_cw,
   input  logic       src_ccw,
   output logic       y
);

   logic [2:0] en;

   always_comb begin
      en = 3'b000;
      case (sel_e'(sel))
         SEL_STRAIGHT: en = 3'b001;
         SEL_CW:       en = 3'b010;
         SEL_CCW:      en = 3'b100;
         default:      en = 3'b000;
      endcase
   end

   assign y = |(en & {src_ccw, src_cw, src_straight});

   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(en));   // R2

   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd0) |-> (y == 1'b0));   // R2

   AST_PATH_STRAIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd1) |-> (y == src_straight));   // R3

   AST_PATH_CW: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd2) |-> (y == src_cw));   // R4

   AST_PATH_CCW: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 2'd3) |-> (y == src_ccw));   // R5

endmodule

// File: rtl/sbox_rotating.sv
module sbox_rotating
   import sbox_pkg::*;
#(
   parameter  int W  = 5,
   localparam int AW = $clog2(4*W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [1:0]    cfg_sel,
   input  logic [W-1:0]  in_n,
   input  logic [W-1:0]  in_e,
   input  logic [W-1:0]  in_s,
   input  logic [W-1:0]  in_w,
   output logic [W-1:0]  out_n,
   output logic [W-1:0]  out_e,
   output logic [W-1:0]  out_s,
   output logic [W-1:0]  out_w
);

   localparam int NUM = 4 * W;

   initial begin
      assert (W >= 2) else $error("track count must be at least 2");
   end

   logic [NUM-1:0][1:0] sel_q;
   logic [W-1:0]        in_side  [4];
   logic [W-1:0]        out_side [4];

   assign in_side[SIDE_N] = in_n;
   assign in_side[SIDE_E] = in_e;
   assign in_side[SIDE_S] = in_s;
   assign in_side[SIDE_W] = in_w;

   assign out_n = out_side[SIDE_N];
   assign out_e = out_side[SIDE_E];
   assign out_s = out_side[SIDE_S];
   assign out_w = out_side[SIDE_W];

   sbox_cfg_regs #(.NUM(NUM), .AW(AW)) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .data  (cfg_sel),
      .sel_q (sel_q)
   );

   for (genvar s = 0; s < 4; s++) begin : g_side
      localparam int OPP = side_step(s, 2);
      localparam int CWS = side_step(s, 1);
      localparam int CCS = side_step(s, 3);
      for (genvar t = 0; t < W; t++) begin : g_track
         localparam int T_UP = track_wrap(t, 1, W);
         localparam int T_DN = track_wrap(t, -1, W);
         sbox_track_mux u_mux (
            .clk          (clk),
            .rst_n        (rst_n),
            .sel          (sel_q[s*W + t]),
            .src_straight (in_side[OPP][t]),
            .src_cw       (in_side[CWS][T_UP]),
            .src_ccw      (in_side[CCS][T_DN]),
            .y            (out_side[s][t])
         );
      end
   end

   AST_WRAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[W-1] == 2'd2) |-> (out_n[W-1] == in_e[0]));   // R6

   AST_WRAP_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[W] == 2'd3) |-> (out_e[0] == in_n[W-1]));   // R6

endmodule

// File: tb/tb_sbox_rotating.sv
module tb_sbox_rotating;

   localparam int CLK_PERIOD = 10;
   localparam int TW  = 5;
   localparam int TAW = $clog2(4*TW);
   localparam int NV  = 16;

   // {side[2], track[3], sel[2], n[5], e[5], s[5], w[5], expected[1]}
   localparam logic [27:0] VEC [NV] = '{
      {2'd0, 3'd2, 2'd1, 5'b00000, 5'b00000, 5'b00100, 5'b00000, 1'b1},
      {2'd0, 3'd2, 2'd1, 5'b11111, 5'b11111, 5'b11011, 5'b11111, 1'b0},
      {2'd0, 3'd2, 2'd2, 5'b00000, 5'b01000, 5'b00000, 5'b00000, 1'b1},
      {2'd0, 3'd2, 2'd2, 5'b11111, 5'b10111, 5'b11111, 5'b11111, 1'b0},
      {2'd0, 3'd2, 2'd3, 5'b00000, 5'b00000, 5'b00000, 5'b00010, 1'b1},
      {2'd1, 3'd0, 2'd1, 5'b00000, 5'b00000, 5'b00000, 5'b00001, 1'b1},
      {2'd1, 3'd4, 2'd2, 5'b00000, 5'b00000, 5'b00001, 5'b00000, 1'b1},
      {2'd1, 3'd0, 2'd3, 5'b10000, 5'b00000, 5'b00000, 5'b00000, 1'b1},
      {2'd2, 3'd3, 2'd2, 5'b00000, 5'b00000, 5'b00000, 5'b10000, 1'b1},
      {2'd2, 3'd1, 2'd3, 5'b00000, 5'b00001, 5'b00000, 5'b00000, 1'b1},
      {2'd3, 3'd4, 2'd1, 5'b00000, 5'b10000, 5'b00000, 5'b00000, 1'b1},
      {2'd3, 3'd2, 2'd2, 5'b01000, 5'b00000, 5'b00000, 5'b00000, 1'b1},
      {2'd3, 3'd0, 2'd3, 5'b00000, 5'b00000, 5'b10000, 5'b00000, 1'b1},
      {2'd2, 3'd4, 2'd2, 5'b00000, 5'b00000, 5'b00000, 5'b00001, 1'b1},
      {2'd0, 3'd0, 2'd0, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 1'b0},
      {2'd3, 3'd3, 2'd3, 5'b11111, 5'b11111, 5'b11011, 5'b11111, 1'b0}
   };

   logic           clk = 1'b0;
   logic           rst_n;
   logic           cfg_we;
   logic [TAW-1:0] cfg_addr;
   logic [1:0]     cfg_sel;
   logic [TW-1:0]  in_n, in_e, in_s, in_w;
   logic [TW-1:0]  out_n, out_e, out_s, out_w;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbox_rotating #(.W(TW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_sel(cfg_sel), .in_n(in_n), .in_e(in_e), .in_s(in_s), .in_w(in_w),
      .out_n(out_n), .out_e(out_e), .out_s(out_s), .out_w(out_w)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic write_cfg(input int side, input int track, input logic [1:0] sel);
      @(negedge clk);
      cfg_we   = 1'b1;
      cfg_addr = TAW'(side*TW + track);
      cfg_sel  = sel;
      @(posedge clk);
      #1;
      cfg_we   = 1'b0;
   endtask

   function automatic logic [TW-1:0] side_in(input int side);
      case (side)
         0: return in_n;
         1: return in_e;
         2: return in_s;
         default: return in_w;
      endcase
   endfunction

   function automatic logic [TW-1:0] side_out(input int side);
      case (side)
         0: return out_n;
         1: return out_e;
         2: return out_s;
         default: return out_w;
      endcase
   endfunction

   // expected output bit from the requirement text
   function automatic logic model_bit(input int side, input int t, input int sel);
      logic [TW-1:0] v;
      case (sel)
         1: begin v = side_in((side+2)%4); return v[t]; end
         2: begin v = side_in((side+1)%4); return v[(t+1)%TW]; end
         3: begin v = side_in((side+3)%4); return v[(t+TW-1)%TW]; end
         default: return 1'b0;
      endcase
   endfunction

   initial begin
      #(CLK_PERIOD*100000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_sel = 2'b00;
      in_n = '1; in_e = '1; in_s = '1; in_w = '1;
      #(CLK_PERIOD*2 + 2);
      // R1: outputs quiet during reset and after release
      chk("R1 reset outputs", {12'd0, out_n, out_e, out_s, out_w}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 after release", {12'd0, out_n, out_e, out_s, out_w}, 32'd0);

      // table walk: R2..R6, with every other output left quiet (R9)
      for (int i = 0; i < NV; i++) begin
         logic [27:0] v;
         int sd, tr;
         logic [TW-1:0] o, rest;
         v  = VEC[i];
         sd = int'(v[27:26]);
         tr = int'(v[25:23]);
         write_cfg(sd, tr, v[22:21]);
         @(negedge clk);
         in_n = v[20:16]; in_e = v[15:11]; in_s = v[10:6]; in_w = v[5:1];
         #1;
         o = side_out(sd);
         chk($sformatf("R3/R4/R5/R6 R2 vector %0d", i), {31'd0, o[tr]}, {31'd0, v[0]});
         rest = o;
         rest[tr] = 1'b0;
         chk($sformatf("R9 others quiet vector %0d", i),
             {12'd0, (sd==0 ? rest : out_n), (sd==1 ? rest : out_e),
                     (sd==2 ? rest : out_s), (sd==3 ? rest : out_w)}, 32'd0);
         write_cfg(sd, tr, 2'b00);
      end

      // R8: out-of-range writes change nothing
      in_n = '1; in_e = '1; in_s = '1; in_w = '1;
      for (int a = 4*TW; a < (1 << TAW); a++) begin
         @(negedge clk);
         cfg_we = 1'b1; cfg_addr = TAW'(a); cfg_sel = 2'b01;
         @(posedge clk); #1;
         cfg_we = 1'b0;
      end
      chk("R8 out of range ignored", {12'd0, out_n, out_e, out_s, out_w}, 32'd0);

      // R7: enable low stores nothing
      @(negedge clk);
      cfg_we = 1'b0; cfg_addr = TAW'(0); cfg_sel = 2'b01;
      @(posedge clk); #1;
      chk("R7 enable low", {27'd0, out_n}, 32'd0);

      // R7: same-cycle write and input change; old route holds before the edge
      @(negedge clk);
      in_s = 5'b00010; in_n = '0; in_e = '0; in_w = '0;
      cfg_we = 1'b1; cfg_addr = TAW'(1); cfg_sel = 2'b01;
      #1;
      chk("R7 before edge", {27'd0, out_n}, 32'd0);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      chk("R7 after edge", {27'd0, out_n}, 32'h2);

      // R9: program all outputs, then change one and recheck all
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < TW; t++)
            write_cfg(s, t, 2'((s + t) % 3 + 1));
      @(negedge clk);
      in_n = 5'b10110; in_e = 5'b01101; in_s = 5'b11001; in_w = 5'b00111;
      #1;
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < TW; t++) begin
            logic [TW-1:0] o;
            o = side_out(s);
            chk($sformatf("R3/R4/R5 full map side %0d track %0d", s, t),
                {31'd0, o[t]}, {31'd0, model_bit(s, t, (s + t) % 3 + 1)});
         end
      write_cfg(2, 2, 2'b00);
      #1;
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < TW; t++) begin
            logic [TW-1:0] o;
            o = side_out(s);
            chk($sformatf("R9 after single rewrite side %0d track %0d", s, t),
                {31'd0, o[t]},
                {31'd0, (s == 2 && t == 2) ? 1'b0 : model_bit(s, t, (s + t) % 3 + 1)});
         end

      // R1: asynchronous reset mid-run
      @(negedge clk);
      #2 rst_n = 1'b0;
      #1;
      chk("R1 async reset clears", {12'd0, out_n, out_e, out_s, out_w}, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk("R1 stays clear", {12'd0, out_n, out_e, out_s, out_w}, 32'd0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule